// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This unit watches the interrupt conditions of one UART channel and reports the most urgent one as a four-bit source code in an 8-bit status byte. There are five sources on four priority levels. A receive line error is the most urgent. Receive data ready and receive timeout share the second level. Transmit holding empty is third, and a modem status change is last. Each source passes through its own enable bit before the priority choice, so a disabled source never shows in the code. The upper status bits tell software whether the FIFOs are on.

Software reads the status byte with a read strobe. The value is frozen when the strobe is first seen and stays frozen until the strobe drops. The source it names is then cleared, but only if that source is the transmit-empty flag. That flag is the only source held in the unit. The other sources are level inputs, and they go away only when their cause is serviced somewhere else.

A small sequencer handles the read cycle. It has three states:
- `RD_IDLE` shows the live value.
- `RD_HOLD` shows the frozen value.
- `RD_DONE` lasts one cycle and issues the clear.

Its transitions are:
- IDLE→HOLD when the strobe is seen high. The live byte is captured on this transition.
- HOLD→DONE when the strobe is seen low.
- DONE→HOLD when the strobe is high again. The byte is captured again.
- DONE→IDLE otherwise.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, `status_o` is 8'h01 with `fifo_mode_i` low, and `irq_o` is low.
- R2: An enabled line error is reported as code 4'b0110 in bits [3:0], whatever the other sources are doing.
- R3: With no enabled line error, an enabled receive timeout gives code 4'b1100. An enabled data ready without a timeout gives 4'b0100.
- R4: With no enabled level-1 or level-2 source, a set and enabled transmit-empty flag gives code 4'b0010.
- R5: A modem change is reported as 4'b0000 only when no higher source is pending. With nothing pending, the code is 4'b0001.
- R6: A source whose enable bit is low never appears in the code.
- R7: Bits [7:6] are 2'b11 when `fifo_mode_i` is high and 2'b00 when it is low. Bits [5:4] are always 0.
- R8: `irq_o` is high exactly when bit 0 of the live status is 0.
- R9: While the strobe stays high after its first sampled edge, `status_o` holds the value captured at that edge and ignores changes at the inputs.
- R10: A read that reported 4'b0010 clears the transmit-empty flag. The clear happens on the second rising edge after the strobe is sampled low, unless a new set event arrives on that same edge.
- R11: The transmit-empty flag is set on a rising edge of (`thr_empty_i` AND `en_thr_i`). This includes enabling the source while the holding register is already empty. A holding-register write clears the flag and wins over a set in the same cycle.
- R12: A status read does not clear the line, receive or modem sources. They clear only when their inputs fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_mode_i | input | 1 | FIFO mode on (sets bits [7:6]) |
| en_line_i | input | 1 | Enable for the line error source |
| en_rx_i | input | 1 | Enable for data ready and timeout |
| en_thr_i | input | 1 | Enable for transmit holding empty |
| en_modem_i | input | 1 | Enable for modem change |
| line_err_i | input | 1 | Line error condition (level) |
| rx_ready_i | input | 1 | Receive data available (level) |
| rx_timeout_i | input | 1 | Receive timeout condition (level) |
| thr_empty_i | input | 1 | Transmit holding register or FIFO empty |
| thr_write_i | input | 1 | Write to the transmit holding register |
| modem_chg_i | input | 1 | Modem status change (level) |
| rd_stb_i | input | 1 | Status register read strobe |
| status_o | output | 8 | Status byte |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the unit with `ARM_ON_ENABLE` = 1. With that setting, turning on the transmit-empty enable while the holding register is already empty raises the flag, so the arm-on-enable path of R11 can be tested. Directed sequences cover three cases: reads that report the transmit flag, reads that report a level source, and a write that lands on a set event. A long random phase then changes the strobe, the enables and all five sources at once, including strobes that rise again in the clear cycle.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
    typedef enum logic [1:0] {RD_IDLE, RD_HOLD, RD_DONE} rd_state_t;

    localparam int unsigned ID_W = 4;
    localparam int unsigned ST_W = 8;
    localparam logic [ID_W-1:0] ID_LINE   = 4'b0110;
    localparam logic [ID_W-1:0] ID_RXDATA = 4'b0100;
    localparam logic [ID_W-1:0] ID_RXTMO  = 4'b1100;
    localparam logic [ID_W-1:0] ID_THR    = 4'b0010;
    localparam logic [ID_W-1:0] ID_MODEM  = 4'b0000;
    localparam logic [ID_W-1:0] ID_NONE   = 4'b0001;
endpackage

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            line_i,
    input  logic            rxd_i,
    input  logic            rxt_i,
    input  logic            thr_i,
    input  logic            modem_i,
    input  logic            en_line_i,
    input  logic            en_rx_i,
    input  logic            en_thr_i,
    input  logic            en_modem_i,
    output logic [ID_W-1:0] id_o
);
    logic g_line, g_rxt, g_rxd, g_thr, g_modem;

    assign g_line  = line_i  & en_line_i;
    assign g_rxt   = rxt_i   & en_rx_i;
    assign g_rxd   = rxd_i   & en_rx_i;
    assign g_thr   = thr_i   & en_thr_i;
    assign g_modem = modem_i & en_modem_i;

    always_comb begin
        if (g_line)       id_o = ID_LINE;
        else if (g_rxt)   id_o = ID_RXTMO;
        else if (g_rxd)   id_o = ID_RXDATA;
        else if (g_thr)   id_o = ID_THR;
        else if (g_modem) id_o = ID_MODEM;
        else              id_o = ID_NONE;
    end

    p_line_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (line_i && en_line_i) |-> id_o == ID_LINE);
    p_tmo_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rxt_i && en_rx_i && !(line_i && en_line_i)) |-> id_o == ID_RXTMO);
    p_masked_thr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en_thr_i |-> id_o != ID_THR);
    p_masked_modem_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en_modem_i |-> id_o != ID_MODEM);
endmodule

// File: rtl/uart_thr_flag.sv
module uart_thr_flag #(
    parameter bit ARM_ON_ENABLE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic empty_i,
    input  logic en_i,
    input  logic wr_i,
    input  logic rd_clr_i,
    output logic flag_o
);
    logic cond, cond_q, set_ev;

    generate
        if (ARM_ON_ENABLE) begin : g_arm
            assign cond = empty_i & en_i;
        end else begin : g_edge
            assign cond = empty_i;
        end
    endgenerate

    assign set_ev = cond & ~cond_q & en_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cond_q <= 1'b0;
            flag_o <= 1'b0;
        end else begin
            cond_q <= cond;
            if (wr_i)          flag_o <= 1'b0;
            else if (set_ev)   flag_o <= 1'b1;
            else if (rd_clr_i) flag_o <= 1'b0;
        end
    end

    p_write_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_i) |-> !flag_o);
    p_read_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_clr_i && !empty_i) |-> !flag_o);
endmodule

// File: rtl/uart_irq_rdseq.sv
module uart_irq_rdseq
    import uart_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_stb_i,
    input  logic [ST_W-1:0] live_i,
    output logic [ST_W-1:0] cap_o,
    output logic            hold_o,
    output logic            clr_thr_o
);
    rd_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE: if (rd_stb_i) state_d = RD_HOLD;
            RD_HOLD: if (!rd_stb_i) state_d = RD_DONE;
            RD_DONE: state_d = rd_stb_i ? RD_HOLD : RD_IDLE;
            default: state_d = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RD_IDLE;
            cap_o   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q != RD_HOLD && rd_stb_i) cap_o <= live_i;
        end
    end

    always_comb begin
        hold_o    = 1'b0;
        clr_thr_o = 1'b0;
        unique case (state_q)
            RD_IDLE: ;
            RD_HOLD: hold_o = 1'b1;
            RD_DONE: clr_thr_o = (cap_o[ID_W-1:0] == ID_THR);
            default: ;
        endcase
    end

    p_clr_after_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_thr_o |-> $past(!rd_stb_i));
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter bit ARM_ON_ENABLE = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fifo_mode_i,
    input  logic       en_line_i,
    input  logic       en_rx_i,
    input  logic       en_thr_i,
    input  logic       en_modem_i,
    input  logic       line_err_i,
    input  logic       rx_ready_i,
    input  logic       rx_timeout_i,
    input  logic       thr_empty_i,
    input  logic       thr_write_i,
    input  logic       modem_chg_i,
    input  logic       rd_stb_i,
    output logic [7:0] status_o,
    output logic       irq_o
);
    logic            thr_flag, clr_thr, hold;
    logic [ID_W-1:0] id;
    logic [ST_W-1:0] live, cap;

    uart_thr_flag #(.ARM_ON_ENABLE(ARM_ON_ENABLE)) u_thr (
        .clk(clk), .rst_n(rst_n), .empty_i(thr_empty_i), .en_i(en_thr_i),
        .wr_i(thr_write_i), .rd_clr_i(clr_thr), .flag_o(thr_flag)
    );

    uart_irq_prio u_prio (
        .clk(clk), .rst_n(rst_n),
        .line_i(line_err_i), .rxd_i(rx_ready_i), .rxt_i(rx_timeout_i),
        .thr_i(thr_flag), .modem_i(modem_chg_i),
        .en_line_i(en_line_i), .en_rx_i(en_rx_i), .en_thr_i(en_thr_i),
        .en_modem_i(en_modem_i), .id_o(id)
    );

    assign live = {{2{fifo_mode_i}}, 2'b00, id};

    uart_irq_rdseq u_rd (
        .clk(clk), .rst_n(rst_n), .rd_stb_i(rd_stb_i), .live_i(live),
        .cap_o(cap), .hold_o(hold), .clr_thr_o(clr_thr)
    );

    assign status_o = hold ? cap : live;
    assign irq_o    = ~id[0];

    p_irq_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !hold |-> (irq_o == !status_o[0]));
    p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && $past(hold)) |-> $stable(status_o));
    p_pad_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !hold |-> (status_o[5:4] == 2'b00 && status_o[7:6] == {2{fifo_mode_i}}));
endmodule

// File: tb/uart_irq_ident_bench.sv
module uart_irq_ident_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fifo = 0, en_line = 0, en_rx = 0, en_thr = 0, en_modem = 0;
    logic line_err = 0, rx_rdy = 0, rx_to = 0, thr_empty = 0, thr_wr = 0, modem = 0, stb = 0;
    logic [7:0] status;
    logic irq;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    // reference model state
    logic       m_flag = 0, m_prev = 0;
    logic [1:0] m_st = 0;   // 0 idle, 1 hold, 2 done
    logic [7:0] m_cap = 0;

    always #2.5 clk = ~clk;

    uart_irq_ident u_uart_irq_ident (
        .clk(clk), .rst_n(rst_n), .fifo_mode_i(fifo),
        .en_line_i(en_line), .en_rx_i(en_rx), .en_thr_i(en_thr), .en_modem_i(en_modem),
        .line_err_i(line_err), .rx_ready_i(rx_rdy), .rx_timeout_i(rx_to),
        .thr_empty_i(thr_empty), .thr_write_i(thr_wr), .modem_chg_i(modem),
        .rd_stb_i(stb), .status_o(status), .irq_o(irq)
    );

    function automatic logic [7:0] live_val(logic flag);
        logic [3:0] c;
        if (line_err && en_line)   c = 4'b0110;
        else if (rx_to && en_rx)   c = 4'b1100;
        else if (rx_rdy && en_rx)  c = 4'b0100;
        else if (flag && en_thr)   c = 4'b0010;
        else if (modem && en_modem) c = 4'b0000;
        else                       c = 4'b0001;
        return {fifo, fifo, 2'b00, c};
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // advance one clock, update the model, compare at the falling edge
    task automatic step(string tag);
        logic [7:0] lv;
        logic cond, clr, set;
        @(posedge clk);
        lv   = live_val(m_flag);
        cond = thr_empty & en_thr;
        set  = cond & ~m_prev;
        clr  = (m_st == 2) && (m_cap[3:0] == 4'b0010);
        if (m_st != 1 && stb) begin m_cap = lv; m_st = 1; end
        else if (m_st == 1 && !stb) m_st = 2;
        else if (m_st == 2) m_st = 0;
        m_prev = cond;
        if (thr_wr) m_flag = 0;
        else if (set) m_flag = 1;
        else if (clr) m_flag = 0;
        @(negedge clk);
        lv = live_val(m_flag);
        chk(tag, status, (m_st == 1) ? m_cap : lv);
        chk({tag, " irq R8"}, {7'b0, irq}, {7'b0, ~lv[0]});
    endtask

    initial begin : watchdog
        #(5ns * 150000);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'h1D5));
        repeat (3) @(negedge clk);
        chk("R1 reset status", status, 8'h01);
        chk("R1 reset irq", {7'b0, irq}, 8'h00);
        rst_n = 1'b1;
        step("R1");
        chk("R1 idle after reset", status, 8'h01);

        en_line = 1; en_rx = 1; en_thr = 1; en_modem = 1;
        line_err = 1; rx_rdy = 1; modem = 1;
        step("R2");
        chk("R2 line first", status, 8'h06);
        line_err = 0;
        step("R3");
        chk("R3 data ready", status, 8'h04);
        rx_to = 1;
        step("R3");
        chk("R3 timeout over data", status, 8'h0C);
        rx_to = 0; rx_rdy = 0; thr_empty = 1;
        step("R4");
        chk("R4 thr empty", status, 8'h02);

        stb = 1;
        step("R9");
        line_err = 1;
        step("R9");
        chk("R9 frozen during read", status, 8'h02);
        line_err = 0; stb = 0;
        step("R10");
        step("R10");
        chk("R10 thr cleared by read, R5 modem", status, 8'h00);

        stb = 1; step("R12"); stb = 0; step("R12"); step("R12");
        chk("R12 modem kept after read", status, 8'h00);
        modem = 0;
        step("R5");
        chk("R5 nothing pending", status, 8'h01);
        chk("R8 irq low", {7'b0, irq}, 8'h00);

        en_modem = 0; modem = 1;
        step("R6");
        chk("R6 disabled modem hidden", status, 8'h01);
        fifo = 1;
        step("R7");
        chk("R7 fifo bits", status, 8'hC1);

        thr_empty = 0; step("R11"); thr_empty = 1; step("R11");
        chk("R11 set on empty", status, 8'hC2);
        thr_wr = 1; step("R11"); thr_wr = 0;
        chk("R11 write clears", status, 8'hC1);
        en_thr = 0; thr_empty = 0; step("R11"); thr_empty = 1; step("R11");
        chk("R6 disabled thr hidden", status, 8'hC1);
        en_thr = 1; step("R11");
        chk("R11 arm on enable", status, 8'hC2);
        thr_wr = 1; step("R11"); thr_wr = 0; thr_empty = 0; step("R11");
        thr_empty = 1; thr_wr = 1; step("R11"); thr_wr = 0;
        chk("R11 write beats set", status, 8'hC1);

        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            r = $urandom;
            fifo      = r[0];
            en_line   = r[1] | r[2];
            en_rx     = r[3] | r[4];
            en_thr    = r[5] | r[6] | r[7];
            en_modem  = r[8] | r[9];
            line_err  = (r[12:10] == 3'd0);
            rx_rdy    = r[13] & r[14];
            rx_to     = (r[17:15] == 3'd0);
            if (r[20:18] == 3'd0) thr_empty = ~thr_empty;
            thr_wr    = (r[24:21] == 4'd0);
            modem     = r[25] & r[26];
            if (r[29:27] < 3'd2) stb = ~stb;
            step("R2 R3 R4 R5 R7 R9 R10 R11 random");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule